// File: doc/BRIEF.md
# Extended-group opcode decoder with cycle costs

This block decodes the second byte of the extended instruction group of an 8-bit processor. It reads one opcode byte per valid strobe and, one clock later, presents an operation class, the register or register-pair selector taken from the opcode's fields and the exact cycle cost in T-states. It also presents the side effects on interrupt mode and on the interrupt enable latches, and a hook pulse for codes that have no defined meaning. Every alias in the opcode map is reproduced: NEG, the return forms and the interrupt-mode set each repeat across several codes.

A small flag unit sits after the output register. It forms the new flag byte for the two operations whose flag rule belongs to decode: a port read into a register, and the transfer of I or R into A. The caller supplies the data byte, the old flags and the current IFF2 level. The arithmetic datapath, the memory and port buses and the repeat sequencing of block transfers belong to other blocks.

Top module: `ed_decoder`

## Requirements
- R1: Reset clears every output to zero. A clock edge with valid_i high captures the decode of opcode_i, and done_o is high in the next cycle. After an edge with valid_i low, done_o is low and the decoded fields keep their last values.
- R2: For opcodes 0x40–0x7F with low bits 000 the class is port read (1). With low bits 001 the class is port write (2). In both cases reg_o is bits 5:3 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 none, 7 A) and the cost is 12. out_zero_o is high only for a port write with reg_o 6. For all other classes reg_o reads 0.
- R3: Low bits 010 give 16-bit subtract with carry (class 3) when bit 3 is 0, and 16-bit add with carry (class 4) when bit 3 is 1. pair_o is bits 5:4 (0 BC, 1 DE, 2 HL, 3 SP) and the cost is 15. For all other classes pair_o reads 0.
- R4: Low bits 011 give a 16-bit store to an absolute address (class 5) when bit 3 is 0, and a 16-bit load from an absolute address (class 6) when bit 3 is 1. pair_o is as in R3 and the cost is 20.
- R5: Every opcode 0x40–0x7F with low bits 100 is NEG (class 7) and costs 8.
- R6: Every opcode 0x40–0x7F with low bits 101 is a return (class 8) that costs 14 and raises iff_copy_o (IFF1 takes IFF2) and pop_pc_o.
- R7: Low bits 110 set the interrupt mode (class 9, cost 8, im_we_o high). 0x46, 0x4E, 0x66 and 0x6E give mode 0. 0x56 and 0x76 give mode 1. 0x5E and 0x7E give mode 2.
- R8: The following codes cost 9: 0x47 moves A to I (class 10), 0x4F moves A to R (class 11), 0x57 moves I to A (class 12) and 0x5F moves R to A (class 13). 0x67 and 0x6F are the nibble rotates (classes 14 and 15) and cost 18.
- R9: 0xA0–0xA3, 0xA8–0xAB, 0xB0–0xB3 and 0xB8–0xBB are block operations (class 16) with a base cost of 16 and no hook.
- R10: Every other code is a NOP (class 0) with no mode or latch effect and a cost of 8, except 0x77, which costs 18. For these codes hook_o is high for exactly the one cycle in which done_o rises, and hook_code_o holds the opcode.
- R11: While the class is port read, flags_o has S (bit 7), Z (bit 6), bit 5 and bit 3 taken from data_i, P/V (bit 2) set for even parity of data_i, H (bit 4) and N (bit 1) cleared, and C (bit 0) equal to f_i bit 0.
- R12: While the class is 12 or 13, flags_o is formed as in R11, except that P/V equals iff2_i.
- R13: For every other class, flags_o equals f_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode strobe |
| opcode_i | input | 8 | Second byte of the extended group |
| data_i | input | 8 | Byte read from the port, or the new A value |
| f_i | input | 8 | Current flag byte |
| iff2_i | input | 1 | Current IFF2 level |
| done_o | output | 1 | Decode result valid |
| class_o | output | 5 | Operation class |
| reg_o | output | 3 | Register selector for port I/O |
| pair_o | output | 2 | Register pair selector |
| tstates_o | output | 5 | Cycle cost in T-states |
| out_zero_o | output | 1 | Port write drives zero |
| im_we_o | output | 1 | Interrupt mode write |
| im_mode_o | output | 2 | New interrupt mode |
| iff_copy_o | output | 1 | Copy IFF2 into IFF1 |
| pop_pc_o | output | 1 | Pop program counter |
| hook_o | output | 1 | One-cycle undefined-code event |
| hook_code_o | output | 8 | Opcode carried by the hook event |
| flags_o | output | 8 | Resulting flag byte |

## Verification
The assertions check on every cycle that done_o follows valid_i by one clock, and that a hook pulse comes only with done_o and carries the strobed byte. They also check that a return always raises both latch and pop effects at a cost of 14, that a mode write never yields mode 3, and that carry survives the flag rules. Whether each alias lands on the right class, selector and cost, and whether fields hold through idle cycles, can only be shown by the bench. It sweeps all 256 codes and then random codes with random data and flags.

// File: rtl/ed_dec_pkg.sv
package ed_dec_pkg;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned CLS_W  = 5;
  localparam int unsigned TS_W   = 5;
  localparam int unsigned REG_W  = 3;
  localparam int unsigned PAIR_W = 2;
  localparam int unsigned IM_W   = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP     = 5'd0,
    CLS_PORT_IN = 5'd1,
    CLS_PORT_OUT= 5'd2,
    CLS_SBC16   = 5'd3,
    CLS_ADC16   = 5'd4,
    CLS_ST16    = 5'd5,
    CLS_LD16    = 5'd6,
    CLS_NEG     = 5'd7,
    CLS_RET     = 5'd8,
    CLS_IM      = 5'd9,
    CLS_LD_I_A  = 5'd10,
    CLS_LD_R_A  = 5'd11,
    CLS_LD_A_I  = 5'd12,
    CLS_LD_A_R  = 5'd13,
    CLS_RRD     = 5'd14,
    CLS_RLD     = 5'd15,
    CLS_BLOCK   = 5'd16
  } cls_e;

  localparam logic [TS_W-1:0] TS_PORT  = TS_W'(12);
  localparam logic [TS_W-1:0] TS_ARITH = TS_W'(15);
  localparam logic [TS_W-1:0] TS_ABS   = TS_W'(20);
  localparam logic [TS_W-1:0] TS_SHORT = TS_W'(8);
  localparam logic [TS_W-1:0] TS_RET   = TS_W'(14);
  localparam logic [TS_W-1:0] TS_IR    = TS_W'(9);
  localparam logic [TS_W-1:0] TS_ROT   = TS_W'(18);
  localparam logic [TS_W-1:0] TS_BLOCK = TS_W'(16);

  localparam int unsigned FB_C  = 0;
  localparam int unsigned FB_N  = 1;
  localparam int unsigned FB_PV = 2;
  localparam int unsigned FB_X  = 3;
  localparam int unsigned FB_H  = 4;
  localparam int unsigned FB_Y  = 5;
  localparam int unsigned FB_Z  = 6;
  localparam int unsigned FB_S  = 7;

  typedef struct packed {
    cls_e              cls;
    logic [REG_W-1:0]  rsel;
    logic [PAIR_W-1:0] pair;
    logic [TS_W-1:0]   ts;
    logic              out_zero;
    logic              im_we;
    logic [IM_W-1:0]   im_mode;
    logic              iff_copy;
    logic              pop_pc;
    logic              hook;
  } dec_t;
endpackage

// File: rtl/ed_op_decode.sv
module ed_op_decode
  import ed_dec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);
  localparam logic [REG_W-1:0] REG_NONE = REG_W'(6);

  logic [2:0] low;
  logic [2:0] y;
  logic       main_row;
  logic       block_row;

  assign low       = op_i[2:0];
  assign y         = op_i[5:3];
  assign main_row  = (op_i[7:6] == 2'b01);
  assign block_row = (op_i[7:5] == 3'b101) && !op_i[2];

  always_comb begin
    dec_o      = '0;
    dec_o.cls  = CLS_NOP;
    dec_o.ts   = TS_SHORT;
    dec_o.hook = 1'b1;
    if (main_row) begin
      dec_o.hook = 1'b0;
      case (low)
        3'd0: begin
          dec_o.cls  = CLS_PORT_IN;
          dec_o.rsel = y;
          dec_o.ts   = TS_PORT;
        end
        3'd1: begin
          dec_o.cls      = CLS_PORT_OUT;
          dec_o.rsel     = y;
          dec_o.ts       = TS_PORT;
          dec_o.out_zero = (y == REG_NONE);
        end
        3'd2: begin
          dec_o.cls  = y[0] ? CLS_ADC16 : CLS_SBC16;
          dec_o.pair = y[2:1];
          dec_o.ts   = TS_ARITH;
        end
        3'd3: begin
          dec_o.cls  = y[0] ? CLS_LD16 : CLS_ST16;
          dec_o.pair = y[2:1];
          dec_o.ts   = TS_ABS;
        end
        3'd4: begin
          dec_o.cls = CLS_NEG;
          dec_o.ts  = TS_SHORT;
        end
        3'd5: begin
          dec_o.cls      = CLS_RET;
          dec_o.ts       = TS_RET;
          dec_o.iff_copy = 1'b1;
          dec_o.pop_pc   = 1'b1;
        end
        3'd6: begin
          dec_o.cls     = CLS_IM;
          dec_o.ts      = TS_SHORT;
          dec_o.im_we   = 1'b1;
          // y[1] clear -> mode 0; otherwise y[0] picks mode 2 over 1
          dec_o.im_mode = y[1] ? (y[0] ? IM_W'(2) : IM_W'(1)) : IM_W'(0);
        end
        default: begin
          case (y)
            3'd0: begin dec_o.cls = CLS_LD_I_A; dec_o.ts = TS_IR;  end
            3'd1: begin dec_o.cls = CLS_LD_R_A; dec_o.ts = TS_IR;  end
            3'd2: begin dec_o.cls = CLS_LD_A_I; dec_o.ts = TS_IR;  end
            3'd3: begin dec_o.cls = CLS_LD_A_R; dec_o.ts = TS_IR;  end
            3'd4: begin dec_o.cls = CLS_RRD;    dec_o.ts = TS_ROT; end
            3'd5: begin dec_o.cls = CLS_RLD;    dec_o.ts = TS_ROT; end
            3'd6: begin dec_o.hook = 1'b1;      dec_o.ts = TS_ROT; end
            default: begin dec_o.hook = 1'b1;   dec_o.ts = TS_SHORT; end
          endcase
        end
      endcase
    end else if (block_row) begin
      dec_o.cls  = CLS_BLOCK;
      dec_o.ts   = TS_BLOCK;
      dec_o.hook = 1'b0;
    end
  end
endmodule

// File: rtl/ed_flag_unit.sv
module ed_flag_unit
  import ed_dec_pkg::*;
(
  input  cls_e            cls_i,
  input  logic [OP_W-1:0] data_i,
  input  logic [OP_W-1:0] f_i,
  input  logic            iff2_i,
  output logic [OP_W-1:0] flags_o
);
  logic par_even;
  assign par_even = ~^data_i;

  always_comb begin
    flags_o = f_i;
    case (cls_i)
      CLS_PORT_IN, CLS_LD_A_I, CLS_LD_A_R: begin
        flags_o        = '0;
        flags_o[FB_S]  = data_i[OP_W-1];
        flags_o[FB_Z]  = ~|data_i;
        flags_o[FB_Y]  = data_i[FB_Y];
        flags_o[FB_X]  = data_i[FB_X];
        flags_o[FB_C]  = f_i[FB_C];
        flags_o[FB_PV] = (cls_i == CLS_PORT_IN) ? par_even : iff2_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ed_decoder.sv
module ed_decoder
  import ed_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [OP_W-1:0]   data_i,
  input  logic [OP_W-1:0]   f_i,
  input  logic              iff2_i,
  output logic              done_o,
  output logic [CLS_W-1:0]  class_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic [TS_W-1:0]   tstates_o,
  output logic              out_zero_o,
  output logic              im_we_o,
  output logic [IM_W-1:0]   im_mode_o,
  output logic              iff_copy_o,
  output logic              pop_pc_o,
  output logic              hook_o,
  output logic [OP_W-1:0]   hook_code_o,
  output logic [OP_W-1:0]   flags_o
);
  dec_t            dec_d;
  dec_t            dec_q;
  logic            done_q;
  logic            hook_q;
  logic [OP_W-1:0] code_q;

  ed_op_decode u_decode (
    .op_i  (opcode_i),
    .dec_o (dec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= '0;
      done_q <= 1'b0;
      hook_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= valid_i;
      hook_q <= valid_i && dec_d.hook;
      if (valid_i) begin
        dec_q  <= dec_d;
        code_q <= opcode_i;
      end
    end
  end

  ed_flag_unit u_flags (
    .cls_i   (dec_q.cls),
    .data_i  (data_i),
    .f_i     (f_i),
    .iff2_i  (iff2_i),
    .flags_o (flags_o)
  );

  assign done_o      = done_q;
  assign class_o     = dec_q.cls;
  assign reg_o       = dec_q.rsel;
  assign pair_o      = dec_q.pair;
  assign tstates_o   = dec_q.ts;
  assign out_zero_o  = dec_q.out_zero;
  assign im_we_o     = done_q && dec_q.im_we;
  assign im_mode_o   = dec_q.im_mode;
  assign iff_copy_o  = done_q && dec_q.iff_copy;
  assign pop_pc_o    = done_q && dec_q.pop_pc;
  assign hook_o      = hook_q;
  assign hook_code_o = code_q;
endmodule

// File: rtl/ed_decoder_chk.sv
module ed_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [7:0] opcode_i,
  input logic [7:0] data_i,
  input logic [7:0] f_i,
  input logic       done_o,
  input logic [4:0] class_o,
  input logic [4:0] tstates_o,
  input logic       im_we_o,
  input logic [1:0] im_mode_o,
  input logic       iff_copy_o,
  input logic       pop_pc_o,
  input logic       hook_o,
  input logic [7:0] hook_code_o,
  input logic [7:0] flags_o
);
  assert_done_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o && !hook_o);
  assert_neg_cost_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && class_o == 5'd7) |-> (tstates_o == 5'd8) && !im_we_o && !iff_copy_o);
  assert_ret_effects_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && class_o == 5'd8) |-> iff_copy_o && pop_pc_o && (tstates_o == 5'd14));
  assert_im_mode_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    im_we_o |-> (class_o == 5'd9) && (im_mode_o != 2'd3));
  assert_hook_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hook_o |-> done_o && (hook_code_o == $past(opcode_i)) && (class_o == 5'd0));
  assert_port_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == 5'd1) |-> (flags_o[0] == f_i[0]) && !flags_o[1] && !flags_o[4]
                          && (flags_o[7] == data_i[7]));
  assert_ir_carry_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == 5'd12 || class_o == 5'd13) |-> (flags_o[0] == f_i[0]) && (flags_o[6] == (data_i == 8'h00)));
  assert_pass_flags_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o != 5'd1 && class_o != 5'd12 && class_o != 5'd13) |-> flags_o == f_i);
endmodule

bind ed_decoder ed_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .opcode_i    (opcode_i),
  .data_i      (data_i),
  .f_i         (f_i),
  .done_o      (done_o),
  .class_o     (class_o),
  .tstates_o   (tstates_o),
  .im_we_o     (im_we_o),
  .im_mode_o   (im_mode_o),
  .iff_copy_o  (iff_copy_o),
  .pop_pc_o    (pop_pc_o),
  .hook_o      (hook_o),
  .hook_code_o (hook_code_o),
  .flags_o     (flags_o)
);

// File: tb/ed_decoder_tb_top.sv
module ed_decoder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] f_i = '0;
  logic       iff2_i = 1'b0;
  logic       done_o;
  logic [4:0] class_o;
  logic [2:0] reg_o;
  logic [1:0] pair_o;
  logic [4:0] tstates_o;
  logic       out_zero_o;
  logic       im_we_o;
  logic [1:0] im_mode_o;
  logic       iff_copy_o;
  logic       pop_pc_o;
  logic       hook_o;
  logic [7:0] hook_code_o;
  logic [7:0] flags_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  ed_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .data_i(data_i), .f_i(f_i), .iff2_i(iff2_i), .done_o(done_o),
    .class_o(class_o), .reg_o(reg_o), .pair_o(pair_o), .tstates_o(tstates_o),
    .out_zero_o(out_zero_o), .im_we_o(im_we_o), .im_mode_o(im_mode_o),
    .iff_copy_o(iff_copy_o), .pop_pc_o(pop_pc_o), .hook_o(hook_o),
    .hook_code_o(hook_code_o), .flags_o(flags_o)
  );

  typedef struct packed {
    logic [4:0] cls;
    logic [2:0] rsel;
    logic [1:0] pair;
    logic [4:0] ts;
    logic       oz;
    logic       imwe;
    logic [1:0] imm;
    logic       iffc;
    logic       pop;
    logic       hook;
  } exp_t;

  function automatic exp_t model(input logic [7:0] op);
    exp_t e;
    e = '0;
    e.ts = 5'd8;
    e.hook = 1'b1;
    if (op inside {[8'hA0:8'hA3], [8'hA8:8'hAB], [8'hB0:8'hB3], [8'hB8:8'hBB]}) begin
      e.cls = 5'd16; e.ts = 5'd16; e.hook = 1'b0;
    end else if (op >= 8'h40 && op <= 8'h7F) begin
      e.hook = 1'b0;
      case (op % 8)
        0: begin e.cls = 5'd1; e.rsel = 3'((op - 8'h40) / 8); e.ts = 5'd12; end
        1: begin e.cls = 5'd2; e.rsel = 3'((op - 8'h40) / 8); e.ts = 5'd12;
                 e.oz = (op == 8'h71); end
        2: begin e.cls = ((op / 8) % 2 == 1) ? 5'd4 : 5'd3;
                 e.pair = 2'((op - 8'h40) / 16); e.ts = 5'd15; end
        3: begin e.cls = ((op / 8) % 2 == 1) ? 5'd6 : 5'd5;
                 e.pair = 2'((op - 8'h40) / 16); e.ts = 5'd20; end
        4: e.cls = 5'd7;
        5: begin e.cls = 5'd8; e.ts = 5'd14; e.iffc = 1'b1; e.pop = 1'b1; end
        6: begin
          e.cls = 5'd9; e.imwe = 1'b1;
          if (op == 8'h56 || op == 8'h76) e.imm = 2'd1;
          else if (op == 8'h5E || op == 8'h7E) e.imm = 2'd2;
          else e.imm = 2'd0;
        end
        default: begin
          case (op)
            8'h47: begin e.cls = 5'd10; e.ts = 5'd9; end
            8'h4F: begin e.cls = 5'd11; e.ts = 5'd9; end
            8'h57: begin e.cls = 5'd12; e.ts = 5'd9; end
            8'h5F: begin e.cls = 5'd13; e.ts = 5'd9; end
            8'h67: begin e.cls = 5'd14; e.ts = 5'd18; end
            8'h6F: begin e.cls = 5'd15; e.ts = 5'd18; end
            8'h77: begin e.hook = 1'b1; e.ts = 5'd18; end
            default: e.hook = 1'b1;
          endcase
        end
      endcase
    end
    return e;
  endfunction

  function automatic logic [7:0] exp_flags(input logic [4:0] cls, input logic [7:0] d,
                                           input logic [7:0] f, input logic i2);
    logic [7:0] r;
    int ones;
    ones = $countones(d);
    r = f;
    if (cls == 5'd1 || cls == 5'd12 || cls == 5'd13) begin
      r = {d[7], (d == 8'h00), d[5], 1'b0, d[3], 1'b0, 1'b0, f[0]};
      r[2] = (cls == 5'd1) ? (ones % 2 == 0) : i2;
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [4:0] cls);
    case (cls)
      5'd1, 5'd2:  return "R2";
      5'd3, 5'd4:  return "R3";
      5'd5, 5'd6:  return "R4";
      5'd7:        return "R5";
      5'd8:        return "R6";
      5'd9:        return "R7";
      5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15: return "R8";
      5'd16:       return "R9";
      default:     return "R10";
    endcase
  endfunction

  function automatic string ftag_of(input logic [4:0] cls);
    if (cls == 5'd1) return "R11";
    if (cls == 5'd12 || cls == 5'd13) return "R12";
    return "R13";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_op(input logic [7:0] op);
    exp_t e;
    string t;
    e = model(op);
    t = tag_of(e.cls);
    @(negedge clk_i);
    valid_i = 1'b1;
    opcode_i = op;
    data_i = 8'($urandom);
    f_i = 8'($urandom);
    iff2_i = 1'($urandom);
    @(negedge clk_i);
    valid_i = 1'b0;
    opcode_i = 8'($urandom);
    check("R1", "done", done_o, 1);
    check(t, "class", class_o, e.cls);
    check(t, "reg", reg_o, e.rsel);
    check(t, "pair", pair_o, e.pair);
    check(t, "tstates", tstates_o, e.ts);
    check(t, "out_zero", out_zero_o, e.oz);
    check(t, "im_we", im_we_o, e.imwe);
    check(t, "im_mode", im_mode_o, e.imm);
    check(t, "iff_copy", iff_copy_o, e.iffc);
    check(t, "pop_pc", pop_pc_o, e.pop);
    check("R10", "hook", hook_o, e.hook);
    if (e.hook) check("R10", "hook_code", hook_code_o, op);
    check(ftag_of(e.cls), "flags", flags_o, exp_flags(e.cls, data_i, f_i, iff2_i));
    @(negedge clk_i);
    check("R1", "done idle", done_o, 0);
    check("R10", "hook one cycle", hook_o, 0);
    check("R1", "class held", class_o, e.cls);
    check("R1", "tstates held", tstates_o, e.ts);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0ED1));
    repeat (3) @(negedge clk_i);
    check("R1", "reset done", done_o, 0);
    check("R1", "reset class", class_o, 0);
    check("R1", "reset tstates", tstates_o, 0);
    check("R1", "reset hook", hook_o, 0);
    rst_ni = 1'b1;
    // directed corners: output zero, aliases, 0x77/0x7F hooks, block edges
    run_op(8'h71); run_op(8'h70); run_op(8'h4C); run_op(8'h7D);
    run_op(8'h4E); run_op(8'h76); run_op(8'h7E); run_op(8'h77);
    run_op(8'h7F); run_op(8'hA0); run_op(8'hBB); run_op(8'hA4);
    run_op(8'h00); run_op(8'hFF); run_op(8'h57); run_op(8'h5F);
    for (int i = 0; i < 256; i++) run_op(8'(i));
    for (int i = 0; i < 400; i++) run_op(8'($urandom));
    // zero data for Z flag on port read and I/R moves
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = 8'h78; data_i = 8'h00; f_i = 8'hFF; iff2_i = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R11", "zero read flags", flags_o, 8'h45);
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = 8'h57; data_i = 8'h80; f_i = 8'h00; iff2_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R12", "I to A flags", flags_o, 8'h84);
    summary();
  end
endmodule